// File: doc/BRIEF.md
# Divider Reprogramming Sequencer

This block rewrites the counter registers of a clock synthesizer through a 16-bit dynamic-configuration port. A requester supplies three divider values (the pre-divider, the feedback multiplier and the post-divider) together with a 32-bit lock word and a 32-bit filter word. The block turns each divider into a high count, a low count, an odd-ratio edge flag and a bypass flag. It packs those fields and slices of the two words into ten register values. It then updates the ten configuration registers one after another.

Each update keeps the bits of the target register that lie outside that register's mask. The block first reads the register, then writes back the old contents outside the mask merged with the new value inside it. A mask of all ones would skip the read. None of the ten masks used here is all ones, so every update is a read followed by a write.

The request side is a valid/ready stream of one beat per job. `req_ready` is high only while the sequencer is idle, and a beat moves on a clock edge where both `req_valid` and `req_ready` are high. The requester may hold `req_valid` high for as long as it likes, and the job fields need to be stable only on the edge of transfer. The configuration port is a request/ready pair. The block holds `drp_req`, the address, the direction and the write data until the cycle in which `drp_rdy` is high, and the port may take any number of cycles to answer. Completion is reported by a one-cycle `done` pulse. A job that is refused is reported by a one-cycle `reject` pulse.

Top module: `divcfg_seq`

## Requirements
- R1: For a divider N the fields are high = floor(N/2), low = N - high and edge = N mod 2, with high and low each kept to 6 bits. The bypass flag is 1 only when N is 1.
- R2: An accepted job writes the configuration registers in this address order: 0x08, 0x09, 0x16, 0x14, 0x15, 0x18, 0x19, 0x1A, 0x4E, 0x4F.
- R3: The post-divider N goes to 0x08 as (high<<6)|low under mask 0xEFFF, and to 0x09 as (edge<<7)|(bypass<<6) under mask 0x03FF. The feedback multiplier goes to 0x14 and 0x15 in the same two layouts with the same two masks.
- R4: The pre-divider goes to 0x16 as (edge<<13)|(bypass<<12)|(high<<6)|low under mask 0x3FFF.
- R5: From the lock word L: register 0x18 gets L[9:0] under mask 0x03FF. Register 0x19 gets (L[20:16]<<10)|0x001 under mask 0x7FFF. Register 0x1A gets (L[28:24]<<10)|0x3E9 under mask 0x7FFF.
- R6: From the filter word F: register 0x4E gets F[31:16] and register 0x4F gets F[15:0], both under mask 0x9900.
- R7: Each write is preceded by a completed read of the same address. The written word is (read & ~mask) | (value & mask).
- R8: A job with any of the three dividers equal to zero is accepted and then refused. `reject` is high in the cycle after the transfer, and no configuration access is issued.
- R9: A configuration access holds `drp_req`, `drp_addr`, `drp_we` and `drp_wdata` steady until the cycle in which `drp_rdy` is high. No access starts before the previous one has completed.
- R10: `done` is high for exactly one cycle, the cycle after the final write completes. `req_ready` is high exactly when no job is in progress, including after reset.
- R11: Job fields are sampled only on the transfer edge. Changes to them while a job runs have no effect on the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Job beat offered |
| req_ready | output | 1 | Sequencer idle, beat can transfer |
| req_div_in | input | DIV_W | Pre-divider value |
| req_fb_mult | input | DIV_W | Feedback multiplier value |
| req_div_out | input | DIV_W | Post-divider value |
| req_lock | input | 32 | Lock word |
| req_filter | input | 32 | Filter word |
| done | output | 1 | One-cycle pulse: job finished |
| reject | output | 1 | One-cycle pulse: job refused |
| drp_req | output | 1 | Configuration access requested |
| drp_we | output | 1 | 1 = write, 0 = read |
| drp_addr | output | 7 | Configuration register address |
| drp_wdata | output | 16 | Write data |
| drp_rdy | input | 1 | Access completes this cycle |
| drp_rdata | input | 16 | Read data, valid while drp_rdy is high |

## Verification
The `done` pulse of one job and the transfer of the next job can fall in the same cycle. This happens because the sequencer becomes idle, and raises `req_ready`, in the very cycle that `done` is high. The bench provokes it by offering the next job while the current one is still running, once with a valid job and once with a zero divider. It then judges that `done` is a single pulse, and that the following job's first read targets 0x08 or the refusal leaves the port silent. The port model answers each access after a varying delay, so the hold rule of R9 is exercised across many stall lengths.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 16;
  localparam int FLD_W     = 6;
  localparam int NUM_STEPS = 10;
  localparam int NUM_DIVS  = 3;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  // divider slots inside the latched job
  localparam int DIV_OUT = 0;
  localparam int DIV_PRE = 1;
  localparam int DIV_FB  = 2;

  typedef struct packed {
    logic [FLD_W-1:0] hi;
    logic [FLD_W-1:0] lo;
    logic             odd;
    logic             bypass;
  } cnt_fields_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] val;
    logic [DATA_W-1:0] mask;
  } cfg_op_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/divcfg_split.sv
module divcfg_split
  import divcfg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] ratio,
  output cnt_fields_t      fields
);
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] rest;

  always_comb begin
    half          = ratio >> 1;
    rest          = ratio - half;
    fields.hi     = half[FLD_W-1:0];
    fields.lo     = rest[FLD_W-1:0];
    fields.odd    = ratio[0];
    fields.bypass = (ratio == DIV_W'(1));
  end
endmodule

// File: rtl/divcfg_optab.sv
module divcfg_optab
  import divcfg_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  cnt_fields_t       f_out,
  input  cnt_fields_t       f_pre,
  input  cnt_fields_t       f_fb,
  input  logic [31:0]       lock_w,
  input  logic [31:0]       filt_w,
  output cfg_op_t           op
);
  always_comb begin
    op = '0;
    unique case (step)
      STEP_W'(0): op = '{7'h08, {4'h0, f_out.hi, f_out.lo}, 16'hEFFF};
      STEP_W'(1): op = '{7'h09, {8'h00, f_out.odd, f_out.bypass, 6'h00}, 16'h03FF};
      STEP_W'(2): op = '{7'h16, {2'b00, f_pre.odd, f_pre.bypass, f_pre.hi, f_pre.lo}, 16'h3FFF};
      STEP_W'(3): op = '{7'h14, {4'h0, f_fb.hi, f_fb.lo}, 16'hEFFF};
      STEP_W'(4): op = '{7'h15, {8'h00, f_fb.odd, f_fb.bypass, 6'h00}, 16'h03FF};
      STEP_W'(5): op = '{7'h18, {6'h00, lock_w[9:0]}, 16'h03FF};
      STEP_W'(6): op = '{7'h19, {1'b0, lock_w[20:16], 10'h001}, 16'h7FFF};
      STEP_W'(7): op = '{7'h1A, {1'b0, lock_w[28:24], 10'h3E9}, 16'h7FFF};
      STEP_W'(8): op = '{7'h4E, filt_w[31:16], 16'h9900};
      STEP_W'(9): op = '{7'h4F, filt_w[15:0], 16'h9900};
      default:    op = '0;
    endcase
  end
endmodule

// File: rtl/divcfg_seq.sv
module divcfg_seq
  import divcfg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [DIV_W-1:0]     req_div_in,
  input  logic [DIV_W-1:0]     req_fb_mult,
  input  logic [DIV_W-1:0]     req_div_out,
  input  logic [31:0]          req_lock,
  input  logic [31:0]          req_filter,
  output logic                 done,
  output logic                 reject,
  output logic                 drp_req,
  output logic                 drp_we,
  output logic [ADDR_W-1:0]    drp_addr,
  output logic [DATA_W-1:0]    drp_wdata,
  input  logic                 drp_rdy,
  input  logic [DATA_W-1:0]    drp_rdata
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic [DIV_W-1:0]  div_q [NUM_DIVS];
  logic [DIV_W-1:0]  div_in [NUM_DIVS];
  cnt_fields_t       fld [NUM_DIVS];
  logic [31:0]       lock_q;
  logic [31:0]       filt_q;
  logic [DATA_W-1:0] merged_q;
  cfg_op_t           op;
  logic              take;
  logic              any_zero;
  logic              full_mask;

  assign div_in[DIV_OUT] = req_div_out;
  assign div_in[DIV_PRE] = req_div_in;
  assign div_in[DIV_FB]  = req_fb_mult;

  // one splitter per latched divider
  for (genvar g = 0; g < NUM_DIVS; g++) begin : g_split
    divcfg_split #(.DIV_W(DIV_W)) u_split (
      .ratio  (div_q[g]),
      .fields (fld[g])
    );
  end

  divcfg_optab u_optab (
    .step   (step),
    .f_out  (fld[DIV_OUT]),
    .f_pre  (fld[DIV_PRE]),
    .f_fb   (fld[DIV_FB]),
    .lock_w (lock_q),
    .filt_w (filt_q),
    .op     (op)
  );

  always_comb begin
    req_ready = (state == ST_IDLE);
    take      = req_valid && req_ready;
    any_zero  = 1'b0;
    for (int i = 0; i < NUM_DIVS; i++) begin
      if (div_in[i] == '0) any_zero = 1'b1;
    end
    full_mask = (op.mask == '1);
    drp_req   = ((state == ST_READ) && !full_mask) || (state == ST_WRITE);
    drp_we    = (state == ST_WRITE);
    drp_addr  = op.addr;
    drp_wdata = (state == ST_WRITE) ? merged_q : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step     <= '0;
      lock_q   <= '0;
      filt_q   <= '0;
      merged_q <= '0;
      done     <= 1'b0;
      reject   <= 1'b0;
      for (int i = 0; i < NUM_DIVS; i++) div_q[i] <= '0;
    end else begin
      done   <= 1'b0;
      reject <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            if (any_zero) begin
              reject <= 1'b1;
            end else begin
              for (int i = 0; i < NUM_DIVS; i++) div_q[i] <= div_in[i];
              lock_q <= req_lock;
              filt_q <= req_filter;
              step   <= '0;
              state  <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (full_mask) begin
            merged_q <= op.val;
            state    <= ST_WRITE;
          end else if (drp_rdy) begin
            merged_q <= (drp_rdata & ~op.mask) | (op.val & op.mask);
            state    <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (drp_rdy) begin
            if (step == LAST_STEP) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              step  <= step + STEP_W'(1);
              state <= ST_READ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divcfg_seq_chk.sv
module divcfg_seq_chk
  import divcfg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              reject,
  input logic              drp_req,
  input logic              drp_we,
  input logic [ADDR_W-1:0] drp_addr,
  input logic [DATA_W-1:0] drp_wdata,
  input logic              drp_rdy
);
  // R9: a stalled access keeps its request, direction, address and data
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drp_req && !drp_rdy |=> drp_req && $stable(drp_we) && $stable(drp_addr) && $stable(drp_wdata));

  // R7: a completed read is followed at once by a write to the same address
  p_read_then_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drp_req && !drp_we && drp_rdy |=> drp_req && drp_we && $stable(drp_addr));

  // R10: done lasts one cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done only after a completed write
  p_done_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(drp_req && drp_we && drp_rdy));

  // R8: a refused job leaves the port idle and the sequencer ready
  p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !drp_req && req_ready);

  // R10: ready only while the port is idle
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !drp_req);

  // R8 / R10: completion and refusal never coincide
  p_excl_pulses_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, reject}));
endmodule

bind divcfg_seq divcfg_seq_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/divcfg_seq_tb.sv
`timescale 1ns/1ps
module divcfg_seq_tb;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_div_in = '0, req_fb_mult = '0, req_div_out = '0;
  logic [31:0] req_lock = '0, req_filter = '0;
  logic        done, reject;
  logic        drp_req, drp_we;
  logic [6:0]  drp_addr;
  logic [15:0] drp_wdata;
  logic        drp_rdy = 1'b0;
  logic [15:0] drp_rdata = '0;

  divcfg_seq #(.DIV_W(DIV_W)) u_dut (.*);

  int checks = 0;
  int fails  = 0;
  logic [15:0] mem    [128];
  logic [15:0] shadow [128];
  logic [6:0]  q_addr [$];
  logic [15:0] q_data [$];
  bit          finished = 1'b0;

  function automatic logic [15:0] seed_word(int a);
    return 16'(a * 16'h1357) ^ 16'hA5A5;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // R1 field split
  task automatic split(int n, output int hi, output int lo, output int e, output int nc);
    hi = (n / 2) % 64;
    lo = (n - n / 2) % 64;
    e  = n % 2;
    nc = (n == 1) ? 1 : 0;
  endtask

  // expected operation per step, R2..R6
  task automatic exp_op(int s, int d, int m, int o, logic [31:0] lk, logic [31:0] fl,
                        output logic [6:0] a, output logic [15:0] v, output logic [15:0] mk);
    int hi, lo, e, nc;
    case (s)
      0, 1: split(o, hi, lo, e, nc);
      2:    split(d, hi, lo, e, nc);
      default: split(m, hi, lo, e, nc);
    endcase
    case (s)
      0: begin a = 7'h08; v = 16'((hi << 6) | lo); mk = 16'hEFFF; end
      1: begin a = 7'h09; v = 16'((e << 7) | (nc << 6)); mk = 16'h03FF; end
      2: begin a = 7'h16; v = 16'((e << 13) | (nc << 12) | (hi << 6) | lo); mk = 16'h3FFF; end
      3: begin a = 7'h14; v = 16'((hi << 6) | lo); mk = 16'hEFFF; end
      4: begin a = 7'h15; v = 16'((e << 7) | (nc << 6)); mk = 16'h03FF; end
      5: begin a = 7'h18; v = {6'h0, lk[9:0]}; mk = 16'h03FF; end
      6: begin a = 7'h19; v = {1'b0, lk[20:16], 10'h001}; mk = 16'h7FFF; end
      7: begin a = 7'h1A; v = {1'b0, lk[28:24], 10'h3E9}; mk = 16'h7FFF; end
      8: begin a = 7'h4E; v = fl[31:16]; mk = 16'h9900; end
      default: begin a = 7'h4F; v = fl[15:0]; mk = 16'h9900; end
    endcase
  endtask

  // scoreboard driver side: push expected writes (R7 merge)
  task automatic push_expected(int d, int m, int o, logic [31:0] lk, logic [31:0] fl);
    logic [6:0] a; logic [15:0] v, mk, w;
    for (int s = 0; s < 10; s++) begin
      exp_op(s, d, m, o, lk, fl, a, v, mk);
      w = (shadow[a] & ~mk) | (v & mk);
      shadow[a] = w;
      q_addr.push_back(a);
      q_data.push_back(w);
    end
  endtask

  task automatic send(int d, int m, int o, logic [31:0] lk, logic [31:0] fl);
    bit ok;
    ok = (d != 0) && (m != 0) && (o != 0);
    @(negedge clk);
    req_div_in = 8'(d); req_fb_mult = 8'(m); req_div_out = 8'(o);
    req_lock = lk; req_filter = fl; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    if (ok) push_expected(d, m, o, lk, fl);
    @(negedge clk);
    req_valid = 1'b0;
    // R11: scramble job fields while the job runs
    req_div_in = 8'h33; req_fb_mult = 8'h00; req_div_out = 8'h77;
    req_lock = 32'hDEADBEEF; req_filter = 32'h0BADF00D;
    chk(reject == !ok, ok ? "R8 no reject on valid job" : "R8 reject pulse", 32'(reject), 32'(!ok));
    if (!ok) chk(!drp_req, "R8 no access", 32'(drp_req), 32'h0);
  endtask

  task automatic wait_idle();
    while (q_addr.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(req_ready, "R10 ready when idle", 32'(req_ready), 32'h1);
  endtask

  // port model with varying latency
  logic [7:0] lfsr = 8'h5B;
  int         wait_cnt = 0;
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (drp_rdy) begin
      drp_rdy <= 1'b0;
    end else if (drp_req) begin
      if (wait_cnt == 0) begin
        drp_rdy <= 1'b1;
        if (drp_we) mem[drp_addr] <= drp_wdata;
        else        drp_rdata <= mem[drp_addr];
        wait_cnt <= int'(lfsr[1:0]);
      end else begin
        wait_cnt <= wait_cnt - 1;
      end
    end
  end

  function automatic string tag_of(logic [6:0] a);
    case (a)
      7'h16:               return "R4 pre-divider word";
      7'h18, 7'h19, 7'h1A: return "R5 lock word";
      7'h4E, 7'h4F:        return "R6 filter word";
      default:             return "R3 divider word";
    endcase
  endfunction

  // monitor side of the scoreboard
  bit          pend = 0, exp_done = 0, last_rd = 0;
  logic [6:0]  p_addr, rd_addr;
  logic        p_we;
  logic [15:0] p_wdata;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend)
        chk(drp_req && drp_addr == p_addr && drp_we == p_we && drp_wdata == p_wdata,
            "R9 hold while stalled", {drp_req, drp_we, drp_addr, drp_wdata}, {1'b1, p_we, p_addr, p_wdata});
      pend = drp_req && !drp_rdy;
      p_addr = drp_addr; p_we = drp_we; p_wdata = drp_wdata;
      if (exp_done) begin
        chk(done, "R10 done pulse", 32'(done), 32'h1);
        exp_done = 0;
      end else if (done) begin
        chk(1'b0, "R10 stray done", 32'h1, 32'h0);
      end
      if (drp_req && drp_rdy) begin
        if (!drp_we) begin
          rd_addr = drp_addr; last_rd = 1;
        end else begin
          chk(last_rd && rd_addr == drp_addr, "R7 read before write", 32'(rd_addr), 32'(drp_addr));
          last_rd = 0;
          if (q_addr.size() == 0) begin
            chk(1'b0, "R2 unexpected write", 32'(drp_addr), 32'h0);
          end else begin
            logic [6:0] ea; logic [15:0] ed;
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            chk(drp_addr == ea, "R2 write order", 32'(drp_addr), 32'(ea));
            chk(drp_wdata == ed, tag_of(ea), 32'(drp_wdata), 32'(ed));
            if (ea == 7'h4F) exp_done = 1;
          end
        end
      end
    end
  end

  // watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog R10 actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    for (int a = 0; a < 128; a++) begin
      mem[a]    = seed_word(a);
      shadow[a] = seed_word(a);
    end
    repeat (4) @(negedge clk);
    chk(req_ready && !drp_req && !done && !reject, "R10 reset state",
        {req_ready, drp_req, done, reject}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R10 ready after reset", 32'(req_ready), 32'h1);

    // R1: all dividers 1 -> bypass flags set
    send(1, 1, 1, 32'h1F1F0113, 32'h01001990);
    wait_idle();
    // R1: odd and even mixes
    send(5, 40, 7, 32'h060603E8, 32'h08008090);
    wait_idle();
    // R1: largest 6-bit counts; all-ones words stress the masks (R5, R6, R7)
    send(3, 64, 126, 32'hFFFFFFFF, 32'hFFFFFFFF);
    wait_idle();
    // R8: each zero divider refused
    send(0, 4, 4, 32'h0, 32'h0);
    send(4, 0, 4, 32'h0, 32'h0);
    send(4, 4, 0, 32'h0, 32'h0);
    repeat (6) begin
      @(negedge clk);
      chk(!drp_req, "R8 port silent after reject", 32'(drp_req), 32'h0);
    end
    // back-to-back: next job offered while the current one runs (R10, R11)
    send(2, 9, 4, 32'h1C1C03E8, 32'h01009890);
    send(80, 13, 2, 32'h1F1F0226, 32'h08009090);
    send(6, 0, 6, 32'h12345678, 32'h9ABCDEF0);
    wait_idle();
    send(9, 23, 11, 32'h0B0B03E8, 32'h00000000);
    wait_idle();
    finish_run();
  end
endmodule